// File: doc/BRIEF.md
# ECC Compare and Single-Bit Corrector

This block checks one 512-byte data chunk against its 24-bit Hamming-style error code. It takes two three-byte codes: the one stored in the spare area and the one just computed from the data. It spreads each code into a 32-bit word, XORs the two words, and counts the set bits in the result. From that count it reports one of four outcomes: the chunk is clean, one data bit is flipped (with its location), the stored code itself is damaged, or the error cannot be corrected. A chunk that has been erased, where the stored code reads all ones and the computed code is zero, is reported as clean.

The bit count runs in a pipeline. A result appears a fixed three cycles after the request, and a new request can be accepted on every cycle. When the caller asks for it, a single-bit error is also repaired in place. The block reads the faulty byte from the chunk buffer and waits one cycle. It then writes the byte back with the indicated bit inverted, and pulses a done flag.

Top module: `eccfix_top`

## Requirements
- R1: Code inputs carry byte0 in bits 7:0, byte1 in 15:8 and byte2 in 23:16. Each code is spread into a 32-bit word with byte0 at 7:0, byte1 at 23:16, the low nibble of byte2 at 11:8, the high nibble of byte2 at 27:24, and zeros elsewhere.
- R2: When the XOR of the two spread words is zero, `resStatus` is 0 (clean), and `resByte` and `resBit` are 0.
- R3: When the XOR has exactly 12 set bits, `resStatus` is 1 (correctable). `resBit` equals XOR bits 18:16 and `resByte` equals XOR bits 27:19.
- R4: When the XOR has exactly one set bit, `resStatus` is 2 (code damaged), and the buffer port is not touched.
- R5: When the XOR has any other nonzero count, and the stored word is 0x0FFF0FFF while the computed word is zero, `resStatus` is 0 (erased chunk accepted).
- R6: Every other nonzero XOR gives `resStatus` 3 (uncorrectable), and the buffer port is not touched. Location outputs are 0 for statuses 0, 2 and 3.
- R7: `resValid` is high for exactly one cycle, three clock edges after `start` is sampled high. Requests on back-to-back cycles give results on back-to-back cycles.
- R8: A status-1 result whose request had `fixEnable` high triggers a repair. `bufRdEn` is high in the cycle after `resValid`, with `bufAddr` = `resByte`. Read data is expected one cycle after the read strobe. Two cycles after the read, `bufWrEn` is high at the same address, and `bufWrData` is the read byte XOR (1 << `resBit`). `fixDone` pulses in the cycle after the write, and no other buffer byte changes.
- R9: A request with `fixEnable` low causes no buffer access, whatever its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compare request, sampled each cycle |
| fixEnable | input | 1 | Repair a correctable error for this request |
| storedCode | input | 24 | Code read from the spare area |
| calcCode | input | 24 | Code computed from the data |
| resValid | output | 1 | One-cycle result strobe |
| resStatus | output | 2 | 0 clean/erased, 1 correctable, 2 code damaged, 3 uncorrectable |
| resByte | output | 9 | Byte index of the flipped bit |
| resBit | output | 3 | Bit index within that byte |
| bufRdEn | output | 1 | Buffer read strobe |
| bufWrEn | output | 1 | Buffer write strobe |
| bufAddr | output | 9 | Buffer byte address |
| bufWrData | output | 8 | Repaired byte |
| bufRdData | input | 8 | Buffer read data, one cycle after the read strobe |
| fixDone | output | 1 | Repair complete pulse |

## Verification
On every cycle the assertions check the timing of the repair. The write follows the read by exactly two cycles at the same address, `fixDone` follows the write, and reads and writes never overlap. They also check the fixed three-cycle result latency, and that a result other than correctable starts no read. Only the bench's scenarios can show that the classification, the extracted location and the repaired byte are correct. These scenarios are random and constructed syndromes, single-bit code damage, erased chunks and the write-count check on untouched bytes.

// File: rtl/eccfix_pkg.sv
package eccfix_pkg;
  localparam int CODE_W   = 24;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 9;
  localparam int BIT_W    = 3;
  localparam int DATA_W   = 8;
  localparam int TOT_W    = $clog2(CODE_W + 1);
  localparam logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;
  localparam int SINGLE_WEIGHT = 12;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXABLE = 2'd1,
    ST_BADCODE = 2'd2,
    ST_FATAL   = 2'd3
  } eccStatus_t;

  typedef enum logic [1:0] {
    FX_IDLE, FX_READ, FX_WAIT, FX_WRITE
  } fixState_t;

  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
    logic loadResult;
    logic armFix;
    logic captureByte;
  } ctrlStrobes_t;

  // spread a packed three-byte code into its 32-bit comparison word
  function automatic logic [WORD_W-1:0] spreadCode(input logic [CODE_W-1:0] c);
    return {4'b0, c[23:20], c[15:8], 4'b0, c[19:16], c[7:0]};
  endfunction
endpackage

// File: rtl/eccfix_datapath.sv
module eccfix_datapath
  import eccfix_pkg::*;
#(
  parameter int GROUP_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [CODE_W-1:0]   storedCode,
  input  logic [CODE_W-1:0]   calcCode,
  input  logic [DATA_W-1:0]   bufRdData,
  output eccStatus_t          resStatus,
  output logic [ADDR_W-1:0]   resByte,
  output logic [BIT_W-1:0]    resBit,
  output logic [ADDR_W-1:0]   bufAddr,
  output logic [DATA_W-1:0]   bufWrData
);
  localparam int GROUPS  = CODE_W / GROUP_W;
  localparam int GCNT_W  = $clog2(GROUP_W + 1);

  // stage 1: meaningful 24 bits of the XOR, packed {word[27:16], word[11:0]}
  logic [CODE_W-1:0] diffS1, diffS2;
  logic              erasedS1, erasedS2;
  logic [WORD_W-1:0] diffWord;
  logic [GCNT_W-1:0] groupCnt [GROUPS];
  logic [GCNT_W-1:0] groupCntQ [GROUPS];
  logic [TOT_W-1:0]  weight;
  eccStatus_t        nextStatus;
  logic [DATA_W-1:0] holdByte;
  logic [BIT_W-1:0]  fixBit;

  assign diffWord = spreadCode(storedCode) ^ spreadCode(calcCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffS1   <= '0;
      erasedS1 <= 1'b0;
    end else if (strobes.loadStage1) begin
      diffS1   <= {diffWord[27:16], diffWord[11:0]};
      erasedS1 <= (spreadCode(storedCode) == ERASED_WORD) &&
                  (spreadCode(calcCode) == '0);
    end
  end

  // stage 2: per-group population counts
  function automatic logic [GCNT_W-1:0] countGroup(input logic [GROUP_W-1:0] v);
    logic [GCNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < GROUP_W; i++) n = n + GCNT_W'(v[i]);
    return n;
  endfunction

  for (genvar g = 0; g < GROUPS; g++) begin : g_pop
    assign groupCnt[g] = countGroup(diffS1[g*GROUP_W +: GROUP_W]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   groupCntQ[g] <= '0;
      else if (strobes.loadStage2) groupCntQ[g] <= groupCnt[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffS2   <= '0;
      erasedS2 <= 1'b0;
    end else if (strobes.loadStage2) begin
      diffS2   <= diffS1;
      erasedS2 <= erasedS1;
    end
  end

  // stage 3: final sum and classification
  always_comb begin
    weight = '0;
    for (int g = 0; g < GROUPS; g++) weight = weight + TOT_W'(groupCntQ[g]);
    if (diffS2 == '0)                     nextStatus = ST_CLEAN;
    else if (weight == TOT_W'(SINGLE_WEIGHT)) nextStatus = ST_FIXABLE;
    else if (weight == TOT_W'(1))         nextStatus = ST_BADCODE;
    else if (erasedS2)                    nextStatus = ST_CLEAN;
    else                                  nextStatus = ST_FATAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resStatus <= ST_CLEAN;
      resByte   <= '0;
      resBit    <= '0;
    end else if (strobes.loadResult) begin
      resStatus <= nextStatus;
      resByte   <= (nextStatus == ST_FIXABLE) ? diffS2[23:15] : '0;
      resBit    <= (nextStatus == ST_FIXABLE) ? diffS2[14:12] : '0;
    end
  end

  // repair path: latched location and held byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr  <= '0;
      fixBit   <= '0;
      holdByte <= '0;
    end else begin
      if (strobes.armFix) begin
        bufAddr <= resByte;
        fixBit  <= resBit;
      end
      if (strobes.captureByte) holdByte <= bufRdData;
    end
  end

  assign bufWrData = holdByte ^ (DATA_W'(1) << fixBit);

  // R2: a zero difference must classify as clean
  p_zero_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadResult && diffS2 == '0) |=> (resStatus == ST_CLEAN && resByte == '0));

  // R8: the byte index driven for a repair does not move during it
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureByte |=> $stable(bufAddr));
endmodule

// File: rtl/eccfix_control.sv
module eccfix_control
  import eccfix_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         fixEnable,
  input  eccStatus_t   resStatus,
  output ctrlStrobes_t strobes,
  output logic         resValid,
  output logic         bufRdEn,
  output logic         bufWrEn,
  output logic         fixDone
);
  logic       validS1, validS2;
  logic       fixReqS1, fixReqS2, fixReqS3;
  fixState_t  state;
  logic       armNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      validS2  <= 1'b0;
      resValid <= 1'b0;
      fixReqS1 <= 1'b0;
      fixReqS2 <= 1'b0;
      fixReqS3 <= 1'b0;
    end else begin
      validS1  <= start;
      validS2  <= validS1;
      resValid <= validS2;
      fixReqS1 <= start & fixEnable;
      fixReqS2 <= fixReqS1;
      fixReqS3 <= fixReqS2;
    end
  end

  assign armNow = (state == FX_IDLE) && resValid && fixReqS3 && (resStatus == ST_FIXABLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= FX_IDLE;
      fixDone <= 1'b0;
    end else begin
      fixDone <= (state == FX_WRITE);
      case (state)
        FX_IDLE:  if (armNow) state <= FX_READ;
        FX_READ:  state <= FX_WAIT;
        FX_WAIT:  state <= FX_WRITE;
        default:  state <= FX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadStage1  = start;
    strobes.loadStage2  = validS1;
    strobes.loadResult  = validS2;
    strobes.armFix      = armNow;
    strobes.captureByte = (state == FX_WAIT);
  end

  assign bufRdEn = (state == FX_READ);
  assign bufWrEn = (state == FX_WRITE);

  // R7: fixed three-edge result latency
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    start |-> ##3 resValid);
  // R8: write two cycles after the read, done one cycle after the write
  p_read_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |=> ##1 bufWrEn);
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> fixDone);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(bufRdEn && bufWrEn));
  // R4, R6, R9: no repair without a correctable, enabled result
  p_no_stray_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == FX_IDLE && resValid && (resStatus != ST_FIXABLE || !fixReqS3)) |=> !bufRdEn);
endmodule

// File: rtl/eccfix_top.sv
module eccfix_top
  import eccfix_pkg::*;
#(
  parameter int GROUP_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        fixEnable,
  input  logic [23:0] storedCode,
  input  logic [23:0] calcCode,
  output logic        resValid,
  output logic [1:0]  resStatus,
  output logic [8:0]  resByte,
  output logic [2:0]  resBit,
  output logic        bufRdEn,
  output logic        bufWrEn,
  output logic [8:0]  bufAddr,
  output logic [7:0]  bufWrData,
  input  logic [7:0]  bufRdData,
  output logic        fixDone
);
  ctrlStrobes_t strobes;
  eccStatus_t   statusQ;

  eccfix_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .fixEnable (fixEnable),
    .resStatus (statusQ),
    .strobes   (strobes),
    .resValid  (resValid),
    .bufRdEn   (bufRdEn),
    .bufWrEn   (bufWrEn),
    .fixDone   (fixDone)
  );

  eccfix_datapath #(.GROUP_W(GROUP_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .storedCode (storedCode),
    .calcCode   (calcCode),
    .bufRdData  (bufRdData),
    .resStatus  (statusQ),
    .resByte    (resByte),
    .resBit     (resBit),
    .bufAddr    (bufAddr),
    .bufWrData  (bufWrData)
  );

  assign resStatus = statusQ;
endmodule

// File: tb/tb_eccfix_top.sv
module tb_eccfix_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, fixEnable = 1'b0;
  logic [23:0] storedCode = '0, calcCode = '0;
  logic resValid, bufRdEn, bufWrEn, fixDone;
  logic [1:0] resStatus;
  logic [8:0] resByte, bufAddr;
  logic [2:0] resBit;
  logic [7:0] bufWrData, bufRdData;

  int compared = 0, mismatched = 0, wrCount = 0, cycles = 0;
  logic [7:0] mem [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  eccfix_top dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bufRdEn) bufRdData <= mem[bufAddr];
    if (bufWrEn) begin
      mem[bufAddr] <= bufWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [23:0] c);
    logic [31:0] w = '0;
    w[7:0] = c[7:0]; w[23:16] = c[15:8]; w[11:8] = c[19:16]; w[27:24] = c[23:20];
    return w;
  endfunction

  // expected {status, byte, bit}
  function automatic logic [13:0] refResult(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] x = widen(s) ^ widen(c);
    int n = $countones(x);
    if (x == 0) return {2'd0, 12'd0};
    if (n == 12) return {2'd1, x[27:19], x[18:16]};
    if (n == 1) return {2'd2, 12'd0};
    if (widen(s) == 32'h0FFF0FFF && widen(c) == 0) return {2'd0, 12'd0};
    return {2'd3, 12'd0};
  endfunction

  // raw code difference for a single flipped data bit at {byteIdx, bitIdx}
  function automatic logic [23:0] syndrome(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] a = {b, k};
    logic [31:0] x = {4'b0, a, 4'b0, ~a};
    return {x[27:24], x[11:8], x[23:16], x[7:0]};
  endfunction

  task automatic runOne(input logic [23:0] s, input logic [23:0] c, input bit fe);
    logic [13:0] e = refResult(s, c);
    int w0;
    logic [7:0] orig;
    @(negedge clk);
    start = 1; storedCode = s; calcCode = c; fixEnable = fe;
    @(negedge clk);
    start = 0; fixEnable = 0;
    check(resValid == 0, "R7 early", resValid, 0);
    @(negedge clk);
    check(resValid == 0, "R7 early", resValid, 0);
    @(negedge clk);
    check(resValid == 1, "R7 valid", resValid, 1);
    check(resStatus == e[13:12], "R2/R3/R4/R5/R6 status", resStatus, e[13:12]);
    check({resByte, resBit} == e[11:0], "R1/R3 location", {resByte, resBit}, e[11:0]);
    w0 = wrCount;
    if (fe && e[13:12] == 2'd1) begin
      orig = mem[e[11:3]];
      @(negedge clk);
      check(bufRdEn && bufAddr == e[11:3], "R8 read", {bufRdEn, bufAddr}, {1'b1, e[11:3]});
      check(resValid == 0, "R7 pulse", resValid, 0);
      @(negedge clk);
      @(negedge clk);
      check(bufWrEn && bufAddr == e[11:3], "R8 write", {bufWrEn, bufAddr}, {1'b1, e[11:3]});
      @(negedge clk);
      check(fixDone == 1, "R8 done", fixDone, 1);
      check(mem[e[11:3]] == (orig ^ (8'd1 << e[2:0])), "R8 byte", mem[e[11:3]], orig ^ (8'd1 << e[2:0]));
      check(wrCount == w0 + 1, "R8 single write", wrCount, w0 + 1);
    end else begin
      repeat (4) @(negedge clk);
      check(wrCount == w0 && !fixDone, "R4/R6/R9 no access", wrCount, w0);
    end
  endtask

  initial begin
    int watchdog = 100000;
    while (cycles < watchdog && compared >= 0) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, watchdog);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!resValid && !bufRdEn && !bufWrEn && !fixDone && resStatus == 0, "reset", resValid, 0);
    rstN = 1;
    // directed: R2 clean, R1/R3 known location, R5 erased, R6 near-erased, R4 code damage
    runOne(24'h3C_A5_17, 24'h3C_A5_17, 1);
    runOne(24'h0 ^ syndrome(9'h1A5, 3'd6), 24'h0, 1);
    runOne(syndrome(9'h000, 3'd0) ^ 24'h123456, 24'h123456, 1);
    runOne(syndrome(9'h1FF, 3'd7) ^ 24'h0F0F0F, 24'h0F0F0F, 1);
    runOne(24'hFFFFFF, 24'h000000, 1);
    runOne(24'hFFFFFF, 24'h000001, 1);
    runOne(24'h800000 ^ 24'h55AA33, 24'h55AA33, 1);
    runOne(syndrome(9'h0C3, 3'd2), 24'h0, 0);
    // R7 back-to-back requests
    @(negedge clk);
    start = 1; storedCode = syndrome(9'h044, 3'd1); calcCode = 0;
    @(negedge clk);
    storedCode = 24'h000010;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    check(resValid && resStatus == 1 && resByte == 9'h044, "R7 first", resStatus, 1);
    @(negedge clk);
    check(resValid && resStatus == 2, "R7 second", resStatus, 2);
    @(negedge clk);
    check(!resValid, "R7 end", resValid, 0);
    repeat (4) @(negedge clk);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [23:0] c = 24'($urandom);
      case ($urandom % 4)
        0: runOne(24'($urandom), c, 1'($urandom));
        1: runOne(c ^ syndrome(9'($urandom), 3'($urandom)), c, 1'($urandom));
        2: runOne(c ^ (24'd1 << ($urandom % 24)), c, 1'($urandom));
        default: runOne(c, c, 1'($urandom));
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule